// File: doc/BRIEF.md
# Sampling and Conversion Sequencer for a Multiplexed SAR Converter

This block times the work of a 10-bit successive-approximation converter that sits behind an eight-way analog multiplexer. A conversion begins with a sampling phase, started either by a falling edge on an active-low hardware start pin or by the rising edge of the register write strobe. In hardware-start mode the sampling phase lasts as long as the pin stays low. In software-start mode it lasts a fixed number of clocks. The conversion phase that follows always lasts a fixed number of clocks. At its end the result word, which a behavioural model of the comparator supplies here, is latched and announced with a one-cycle valid strobe.

The block drives the multiplexer address. In single mode the address is the configured channel select. In sweep mode the address walks through a group of 2, 4, 6 or 8 channels, one step per conversion. A status output serves either as a level that marks the converting phase or as a sticky interrupt that a read clears. A power-state output tells the analog section to nap between conversions, or to shut down fully when the software power-down bit is set.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the block is idle: sampling, converting and result_valid are 0, status_n is 1, chan_addr is 0 in sweep mode and pwr_mode is 2'b01 (nap).
- R2: In hardware-start mode (cfg_sw_start=0), a falling edge on start_n while idle raises sampling from the next clock edge. Sampling stays high for as many clock cycles as start_n is seen low, and converting rises at the edge where start_n is first seen high again.
- R3: In software-start mode (cfg_sw_start=1), a rising edge on wr_n while idle starts a sampling phase of exactly SAMP_CYC (default 2) cycles, which is followed by the conversion.
- R4: The converting phase lasts exactly CONV_CYC (default 16) cycles. On the edge where it ends, result takes the value of cmp_result and result_valid is 1 for exactly one cycle.
- R5: In single mode (cfg_sweep=0), chan_addr equals cfg_chan_sel.
- R6: In sweep mode, chan_addr starts at 0 and advances by one after each conversion. It wraps to 0 after the last channel of the group. Select code 0 gives channels 0 to 1, code 1 gives 0 to 3, code 2 gives 0 to 5 and code 3 gives 0 to 7.
- R7: In sweep mode, select codes 4 to 7 act as the two-channel sweep (channels 0 and 1).
- R8: With cfg_eoc_mode=1, status_n is 0 exactly while converting is 1 and is 1 otherwise.
- R9: With cfg_eoc_mode=0, status_n goes to 0 on the edge where a conversion ends and returns to 1 on the edge that sees a falling edge of rd_n.
- R10: A start request that arrives while sampling or converting has no effect. The running conversion keeps its length and produces a single result_valid pulse.
- R11: While cfg_pwr_down is 1, no start request is accepted. pwr_mode is 2'b00 while sampling or converting, 2'b10 when idle with cfg_pwr_down=1, and 2'b01 when idle otherwise.
- R12: In software-start mode start_n has no effect, and in hardware-start mode wr_n has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sw_start | input | 1 | 1: start on write strobe, 0: start on start_n |
| cfg_eoc_mode | input | 1 | 1: status is converting level, 0: sticky interrupt |
| cfg_sweep | input | 1 | 1: sweep mode, 0: single channel |
| cfg_pwr_down | input | 1 | Software power-down; blocks starts |
| cfg_chan_sel | input | CH_W (3) | Channel in single mode, group code in sweep mode |
| start_n | input | 1 | Hardware start pin, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_result | input | RES_W (10) | Behavioural converter result |
| chan_addr | output | CH_W (3) | Multiplexer address |
| sampling | output | 1 | Sampling phase |
| converting | output | 1 | Conversion phase |
| result_valid | output | 1 | One-cycle strobe at the end of a conversion |
| result | output | RES_W (10) | Latched result |
| status_n | output | 1 | Interrupt or end-of-conversion flag, active low |
| pwr_mode | output | 2 | 00 active, 01 nap, 10 shutdown |

## Verification
A wrong phase or a wrong counter shows at the ports within one cycle, because sampling, converting and pwr_mode are compared with the reference model on every clock. A miscounted conversion also shows as a result_valid pulse or a latched value that arrives on the wrong edge. A corrupt sweep index appears on chan_addr in the first cycle after the conversion that moved it. A lost or stuck interrupt shows on status_n at the end edge of the conversion, or at the first read that follows it.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_CONV   = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      PWR_ACTIVE   = 2'b00,
      PWR_NAP      = 2'b01,
      PWR_SHUTDOWN = 2'b10
   } pwr_e;
endpackage

// File: rtl/pin_edge.sv
// Registers an active-low pin and reports one chosen edge for one cycle.
module pin_edge #(
   parameter bit RISE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic evt
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= pin;
   end

   generate
      if (RISE) begin : g_rise
         assign evt = ~prev & pin;
      end else begin : g_fall
         assign evt = prev & ~pin;
      end
   endgenerate
endmodule

// File: rtl/phase_timer.sv
// Idle / sample / convert sequencing with one shared cycle counter.
module phase_timer
   import sarseq_pkg::*;
#(
   parameter int CONV_CYC = 16,
   parameter int SAMP_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sw_mode,
   input  logic   pwr_down,
   input  logic   hw_fall,
   input  logic   sw_rise,
   input  logic   hw_level,
   output phase_e phase,
   output logic   done
);
   localparam int MAXC  = (CONV_CYC > SAMP_CYC) ? CONV_CYC : SAMP_CYC;
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
   localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMP_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             start_req;
   logic             samp_end;

   assign start_req = !pwr_down && (sw_mode ? sw_rise : hw_fall);
   assign samp_end  = sw_mode ? (cnt == SAMP_LAST) : hw_level;
   assign done      = (phase == PH_CONV) && (cnt == CONV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start_req) phase <= PH_SAMPLE;
            end
            PH_SAMPLE: begin
               if (samp_end) begin
                  phase <= PH_CONV;
                  cnt   <= '0;
               end else if (sw_mode) begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_CONV: begin
               if (done) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/chan_sweep.sv
// Channel address: direct select or a wrapping sweep over a group.
module chan_sweep #(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sweep,
   input  logic [CH_W-1:0] sel,
   input  logic            done,
   output logic [CH_W-1:0] chan
);
   localparam int NUM_CH = 1 << CH_W;
   localparam int NGRP   = (NUM_CH / 2 > 0) ? NUM_CH / 2 : 1;

   logic [CH_W-1:0] idx;
   logic [CH_W-1:0] last;

   always_comb begin
      if (int'(sel) < NGRP) last = CH_W'(2 * int'(sel) + 1);
      else                  last = CH_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (!sweep) idx <= '0;
      else if (done)   idx <= (idx >= last) ? '0 : idx + 1'b1;
   end

   assign chan = sweep ? idx : sel;
endmodule

// File: rtl/flag_gen.sv
// Status flag: converting level or sticky interrupt cleared by a read.
module flag_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_mode,
   input  logic conv_act,
   input  logic done,
   input  logic rd_fall,
   output logic status_n
);
   logic irq_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_n <= 1'b1;
      else if (done)    irq_n <= 1'b0;
      else if (rd_fall) irq_n <= 1'b1;
   end

   assign status_n = eoc_mode ? ~conv_act : irq_n;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sarseq_pkg::*;
#(
   parameter int CH_W     = 3,
   parameter int RES_W    = 10,
   parameter int CONV_CYC = 16,
   parameter int SAMP_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_sw_start,
   input  logic             cfg_eoc_mode,
   input  logic             cfg_sweep,
   input  logic             cfg_pwr_down,
   input  logic [CH_W-1:0]  cfg_chan_sel,
   input  logic             start_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [RES_W-1:0] cmp_result,
   output logic [CH_W-1:0]  chan_addr,
   output logic             sampling,
   output logic             converting,
   output logic             result_valid,
   output logic [RES_W-1:0] result,
   output logic             status_n,
   output logic [1:0]       pwr_mode
);
   generate
      if (CH_W < 1)     begin : g_bad_ch   $error("CH_W must be at least 1"); end
      if (RES_W < 1)    begin : g_bad_res  $error("RES_W must be at least 1"); end
      if (CONV_CYC < 2) begin : g_bad_conv $error("CONV_CYC must be at least 2"); end
      if (SAMP_CYC < 1) begin : g_bad_samp $error("SAMP_CYC must be at least 1"); end
   endgenerate

   logic   hw_fall, sw_rise, rd_fall, done;
   phase_e phase;

   pin_edge #(.RISE(1'b0)) u_start_edge (.clk(clk), .rst_n(rst_n), .pin(start_n), .evt(hw_fall));
   pin_edge #(.RISE(1'b1)) u_wr_edge    (.clk(clk), .rst_n(rst_n), .pin(wr_n),    .evt(sw_rise));
   pin_edge #(.RISE(1'b0)) u_rd_edge    (.clk(clk), .rst_n(rst_n), .pin(rd_n),    .evt(rd_fall));

   phase_timer #(.CONV_CYC(CONV_CYC), .SAMP_CYC(SAMP_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_mode  (cfg_sw_start),
      .pwr_down (cfg_pwr_down),
      .hw_fall  (hw_fall),
      .sw_rise  (sw_rise),
      .hw_level (start_n),
      .phase    (phase),
      .done     (done)
   );

   chan_sweep #(.CH_W(CH_W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .sweep (cfg_sweep),
      .sel   (cfg_chan_sel),
      .done  (done),
      .chan  (chan_addr)
   );

   assign sampling   = (phase == PH_SAMPLE);
   assign converting = (phase == PH_CONV);

   flag_gen u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .eoc_mode (cfg_eoc_mode),
      .conv_act (converting),
      .done     (done),
      .rd_fall  (rd_fall),
      .status_n (status_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         result       <= '0;
      end else begin
         result_valid <= done;
         if (done) result <= cmp_result;
      end
   end

   always_comb begin
      if (phase != PH_IDLE)  pwr_mode = PWR_ACTIVE;
      else if (cfg_pwr_down) pwr_mode = PWR_SHUTDOWN;
      else                   pwr_mode = PWR_NAP;
   end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int CH_W  = 3,
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_sw_start,
   input logic             cfg_eoc_mode,
   input logic             cfg_pwr_down,
   input logic             start_n,
   input logic             sampling,
   input logic             converting,
   input logic             result_valid,
   input logic             status_n,
   input logic [CH_W-1:0]  chan_addr,
   input logic [RES_W-1:0] result
);
   p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sampling && converting));

   p_sample_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sampling && !cfg_sw_start && !start_n) |=> sampling);

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   p_conv_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(converting) |-> result_valid);

   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      converting |=> (converting || result_valid));

   p_eoc_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_eoc_mode |-> (status_n == !converting));

   p_pd_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pwr_down && !sampling && !converting) |=> !sampling);
endmodule

bind sar_seq_ctrl sar_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_sw_start (cfg_sw_start),
   .cfg_eoc_mode (cfg_eoc_mode),
   .cfg_pwr_down (cfg_pwr_down),
   .start_n      (start_n),
   .sampling     (sampling),
   .converting   (converting),
   .result_valid (result_valid),
   .status_n     (status_n),
   .chan_addr    (chan_addr),
   .result       (result)
);

// File: tb/tb_sar_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sar_seq_ctrl;
   localparam int CONV = 16;
   localparam int SAMP = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_sw_start = 1'b0, cfg_eoc_mode = 1'b0, cfg_sweep = 1'b0, cfg_pwr_down = 1'b0;
   logic [2:0] cfg_chan_sel = 3'd0;
   logic       start_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [9:0] cmp_result = 10'd5;
   logic [2:0] chan_addr;
   logic       sampling, converting, result_valid, status_n;
   logic [9:0] result;
   logic [1:0] pwr_mode;

   int total = 0, bad = 0;
   bit fin = 0;
   int n_samp = 0, n_conv = 0, n_valid = 0, last_chan = 0;

   // reference model state
   int m_st = 0, m_cnt = 0, m_idx = 0, m_res = 0;
   bit m_rv = 0, m_irq = 1, p_st = 1, p_wr = 1, p_rd = 1;

   always #2 clk = ~clk;

   sar_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_sw_start(cfg_sw_start), .cfg_eoc_mode(cfg_eoc_mode),
      .cfg_sweep(cfg_sweep), .cfg_pwr_down(cfg_pwr_down), .cfg_chan_sel(cfg_chan_sel),
      .start_n(start_n), .wr_n(wr_n), .rd_n(rd_n), .cmp_result(cmp_result),
      .chan_addr(chan_addr), .sampling(sampling), .converting(converting),
      .result_valid(result_valid), .result(result), .status_n(status_n), .pwr_mode(pwr_mode)
   );

   always @(negedge clk) cmp_result <= cmp_result + 10'd37;

   task automatic chk(input int act, input int exp, input string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_idx = 0; m_res = 0; m_rv = 0; m_irq = 1;
         p_st = 1; p_wr = 1; p_rd = 1;
      end else begin
         bit f_st, r_wr, f_rd, fin_c;
         int last;
         f_st = p_st && !start_n;
         r_wr = !p_wr && wr_n;
         f_rd = p_rd && !rd_n;
         fin_c = (m_st == 2) && (m_cnt == CONV - 1);
         m_rv = fin_c;
         if (fin_c) m_res = cmp_result;
         if (fin_c) m_irq = 0; else if (f_rd) m_irq = 1;
         last = (cfg_chan_sel < 4) ? 2 * cfg_chan_sel + 1 : 1;
         if (!cfg_sweep) m_idx = 0;
         else if (fin_c) m_idx = (m_idx >= last) ? 0 : m_idx + 1;
         if (m_st == 0) begin
            if (!cfg_pwr_down && (cfg_sw_start ? r_wr : f_st)) begin m_st = 1; m_cnt = 0; end
         end else if (m_st == 1) begin
            if (cfg_sw_start) begin
               if (m_cnt == SAMP - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
            end else if (start_n) begin m_st = 2; m_cnt = 0; end
         end else begin
            if (fin_c) begin m_st = 0; m_cnt = 0; end else m_cnt++;
         end
         p_st = start_n; p_wr = wr_n; p_rd = rd_n;
      end
   end

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !fin) begin
         chk(sampling, m_st == 1, "R2 sampling");
         chk(converting, m_st == 2, "R4 converting");
         chk(result_valid, m_rv, "R4 result_valid");
         if (m_rv) chk(result, m_res, "R4 result");
         chk(chan_addr, cfg_sweep ? m_idx : cfg_chan_sel, "R6 chan_addr");
         chk(status_n, cfg_eoc_mode ? (m_st != 2) : m_irq, "R9 status_n");
         chk(pwr_mode, (m_st != 0) ? 0 : (cfg_pwr_down ? 2 : 1), "R11 pwr_mode");
         if (sampling) n_samp++;
         if (converting) begin n_conv++; last_chan = chan_addr; end
         if (result_valid) n_valid++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr();
      n_samp = 0; n_conv = 0; n_valid = 0;
   endtask

   task automatic hw_conv(input int low);
      start_n = 1'b0; tick(low); start_n = 1'b1; tick(CONV + 3);
   endtask

   task automatic sw_conv();
      wr_n = 1'b0; tick(1); wr_n = 1'b1; tick(CONV + SAMP + 3);
   endtask

   task automatic sweep_run(input int code, input int n);
      cfg_sweep = 1'b0; tick(1);
      cfg_chan_sel = 3'(code); cfg_sweep = 1'b1; tick(1);
      for (int i = 0; i < n; i++) begin
         int last;
         last = (code < 4) ? 2 * code + 1 : 1;
         hw_conv(1);
         chk(last_chan, i % (last + 1), code < 4 ? "R6 sweep channel" : "R7 invalid code sweep");
      end
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      cfg_sweep = 1'b1;
      #1;
      // R1 reset state
      chk(sampling, 0, "R1 sampling");
      chk(converting, 0, "R1 converting");
      chk(result_valid, 0, "R1 result_valid");
      chk(status_n, 1, "R1 status_n");
      chk(chan_addr, 0, "R1 chan_addr");
      chk(pwr_mode, 1, "R1 pwr_mode");
      tick(1); cfg_sweep = 1'b0; tick(1);

      // R2 / R4 hardware start, sampling follows pin width
      clr(); hw_conv(3);
      chk(n_samp, 3, "R2 sample width 3");
      chk(n_conv, CONV, "R4 conversion length");
      chk(n_valid, 1, "R4 single valid");
      clr(); hw_conv(7);
      chk(n_samp, 7, "R2 sample width 7");

      // R9 interrupt form
      chk(status_n, 0, "R9 int low after conversion");
      rd_n = 1'b0; tick(1); rd_n = 1'b1; tick(1);
      chk(status_n, 1, "R9 int cleared by read");

      // R8 end-of-conversion form
      cfg_eoc_mode = 1'b1; tick(1);
      start_n = 1'b0; tick(1); start_n = 1'b1; tick(5);
      chk(status_n, 0, "R8 low while converting");
      tick(CONV);
      chk(status_n, 1, "R8 high when idle");
      cfg_eoc_mode = 1'b0;

      // R10 start during conversion ignored
      clr();
      start_n = 1'b0; tick(1); start_n = 1'b1; tick(4);
      start_n = 1'b0; tick(1); start_n = 1'b1; tick(CONV + 6);
      chk(n_valid, 1, "R10 one result");
      chk(n_conv, CONV, "R10 length kept");

      // R3 software start
      cfg_sw_start = 1'b1; tick(1);
      clr(); sw_conv();
      chk(n_samp, SAMP, "R3 fixed sample length");
      chk(n_conv, CONV, "R3 conversion follows");

      // R12 wrong-source starts ignored
      clr(); hw_conv(2);
      chk(n_samp + n_conv, 0, "R12 start_n ignored in sw mode");
      cfg_sw_start = 1'b0; tick(1);
      clr(); wr_n = 1'b0; tick(1); wr_n = 1'b1; tick(CONV);
      chk(n_samp + n_conv, 0, "R12 wr_n ignored in hw mode");

      // R11 power down
      cfg_pwr_down = 1'b1; tick(1);
      chk(pwr_mode, 2, "R11 shutdown code");
      clr(); hw_conv(2);
      chk(n_samp + n_conv, 0, "R11 no start while powered down");
      cfg_pwr_down = 1'b0; tick(1);
      chk(pwr_mode, 1, "R11 nap code");

      // R5 single channel
      cfg_chan_sel = 3'd5; tick(1);
      chk(chan_addr, 5, "R5 direct select");
      hw_conv(1);
      chk(last_chan, 5, "R5 channel during conversion");

      // R6 / R7 sweeps
      sweep_run(1, 5);
      sweep_run(0, 3);
      sweep_run(2, 7);
      sweep_run(3, 9);
      sweep_run(6, 3);

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!fin) begin
         fin = 1;
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule